// File: doc/BRIEF.md
# DRAM Test-Mode 4:1 Compression Datapath

This block sits between the decoded strobe events of a by-4 DRAM and a 16-bit internal storage word. Each of the four external data bits owns a group of four internal sub-block bits. In normal operation, the two lowest column address bits pick one bit of each group. A read returns that bit, and a write updates only that bit, using a per-bit write mask toward storage.

A write-enable-and-CAS-before-RAS cycle whose row address has its low ten bits all set switches the block into a compression test mode. While in test mode, a write copies each data bit into all four bits of its group at once. A read reports per data bit whether its four stored bits agree: 1 for equal, 0 for different. Test mode stays on through ordinary read/write rows and through further write-CAS-before-RAS cycles. It is cleared by a CAS-before-RAS refresh, a hidden refresh (which is also CAS-before-RAS at the port), or a RAS-only refresh. A RAS-only refresh is a row that opens and closes with no column access.

Storage is a synchronous-read array outside the block. Read data returns on `rd_data` one clock after the column access, flagged by `rd_valid`.

Top module: `tmc_datapath`

## Requirements
- R1: After reset, `test_mode` and `rd_valid` are 0 and `mem_en` is 0.
- R2: A `ras_fall` with `cas_low` and `we_low` high, and `row_addr[9:0]` all ones, sets `test_mode` on the next clock. Row bits above bit 9 do not matter.
- R3: A write-CAS-before-RAS cycle with any of `row_addr[9:0]` at 0 leaves `test_mode` at 0 when it was 0.
- R4: A `ras_fall` with `cas_low` high and `we_low` low (CAS-before-RAS or hidden refresh) clears `test_mode` on the next clock.
- R5: A row opened by `ras_fall` without `cas_low`, then closed by `ras_rise` with no column access in between, clears `test_mode` on the next clock.
- R6: In test mode, a row that has at least one column access, and any write-CAS-before-RAS cycle (qualifying or not), leave `test_mode` at 1.
- R7: Normal write: storage bit 4*i+s holds data bit i in sub-block s, where s = `col_addr[1:0]`. `mem_wmask` has exactly bits 4*i+s set, and `mem_wdata[4*i+s]` = `wr_data[i]`.
- R8: Normal read: `rd_valid` is 1 one clock after the access, and `rd_data[i]` = stored bit 4*i+s.
- R9: Test-mode write: `mem_wmask` is all ones, and `mem_wdata[4*i+k]` = `wr_data[i]` for all k.
- R10: Test-mode read: `rd_data[i]` is 1 exactly when stored bits 4*i to 4*i+3 are all equal. The sub-block select has no effect.
- R11: A column access drives `mem_en` only while a normally opened row is open.
- R12: `mem_row` is the row address taken at the opening `ras_fall`, and `mem_col` is `col_addr` without its two lowest bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ras_fall | input | 1 | Row strobe falling event |
| ras_rise | input | 1 | Row strobe rising event |
| cas_low | input | 1 | Column strobe is low at the row strobe fall |
| we_low | input | 1 | Write enable is low at the row strobe fall |
| row_addr | input | ROW_W | Row address at the row strobe fall |
| col_valid | input | 1 | Column access event |
| col_write | input | 1 | Column access is a write |
| col_addr | input | COL_W | Column address, two lowest bits select the sub-block |
| wr_data | input | IO_W | External write data |
| test_mode | output | 1 | Compression test mode active |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | IO_W | Read data or per-bit equality flags |
| mem_en | output | 1 | Storage access enable |
| mem_wr | output | 1 | Storage write |
| mem_row | output | ROW_W | Storage row |
| mem_col | output | COL_W-2 | Storage word column |
| mem_wmask | output | 4*IO_W | Storage per-bit write mask |
| mem_wdata | output | 4*IO_W | Storage write data |
| mem_rdata | input | 4*IO_W | Storage read data, one clock after access |

## Verification
The hardest case to reach is a test-mode read that returns a mix of equal and unequal groups. Compression writes always make the four bits of a group equal, so a group can only hold differing bits if they were written in normal mode. The bench therefore leaves test mode with a refresh, writes single sub-block bits of a word with chosen values, and re-enters through a qualifying write-CAS-before-RAS cycle. It then reads that word back under every sub-block select. A RAS-only exit is reached the same way, by opening and closing a row with no column event, and is contrasted with a row that carries a read.

// File: rtl/tmc_datapath.sv
module tmc_datapath #(
  parameter int IO_W    = 4,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 10,
  parameter int ENTRY_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ras_fall,
  input  logic                  ras_rise,
  input  logic                  cas_low,
  input  logic                  we_low,
  input  logic [ROW_W-1:0]      row_addr,
  input  logic                  col_valid,
  input  logic                  col_write,
  input  logic [COL_W-1:0]      col_addr,
  input  logic [IO_W-1:0]       wr_data,
  output logic                  test_mode,
  output logic                  rd_valid,
  output logic [IO_W-1:0]       rd_data,
  output logic                  mem_en,
  output logic                  mem_wr,
  output logic [ROW_W-1:0]      mem_row,
  output logic [COL_W-3:0]      mem_col,
  output logic [4*IO_W-1:0]     mem_wmask,
  output logic [4*IO_W-1:0]     mem_wdata,
  input  logic [4*IO_W-1:0]     mem_rdata
);
  localparam int SUB   = 4;
  localparam int SEL_W = 2;

  logic             row_open, col_seen, rd_mode;
  logic [SEL_W-1:0] rd_sel;
  logic [ROW_W-1:0] row_q;

  wire cbr      = ras_fall & cas_low;
  wire entry_ok = &row_addr[ENTRY_W-1:0];
  wire ror_exit = ras_rise & row_open & ~col_seen;

  assign mem_en  = col_valid & row_open;
  assign mem_wr  = mem_en & col_write;
  assign mem_row = row_q;
  assign mem_col = col_addr[COL_W-1:SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_mode <= 1'b0;
      row_open  <= 1'b0;
      col_seen  <= 1'b0;
      row_q     <= '0;
      rd_valid  <= 1'b0;
      rd_sel    <= '0;
      rd_mode   <= 1'b0;
    end else begin
      if (ras_fall) begin
        row_open <= ~cas_low;
        col_seen <= 1'b0;
        if (!cas_low) row_q <= row_addr;
      end else if (ras_rise) begin
        row_open <= 1'b0;
      end else if (mem_en) begin
        col_seen <= 1'b1;
      end

      if (cbr)           test_mode <= we_low & (test_mode | entry_ok);
      else if (ror_exit) test_mode <= 1'b0;

      rd_valid <= mem_en & ~col_write;
      rd_sel   <= col_addr[SEL_W-1:0];
      rd_mode  <= test_mode;
    end
  end

  for (genvar i = 0; i < IO_W; i++) begin : g_io
    wire [SUB-1:0] grp = mem_rdata[i*SUB +: SUB];
    for (genvar s = 0; s < SUB; s++) begin : g_sub
      assign mem_wdata[i*SUB+s] = wr_data[i];
      assign mem_wmask[i*SUB+s] = test_mode | (col_addr[SEL_W-1:0] == SEL_W'(s));
    end
    assign rd_data[i] = rd_mode ? ((&grp) | ~(|grp)) : grp[rd_sel];
  end
endmodule

module tmc_datapath_chk #(
  parameter int IO_W    = 4,
  parameter int ROW_W   = 12,
  parameter int ENTRY_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_fall,
  input logic              cas_low,
  input logic              we_low,
  input logic [ROW_W-1:0]  row_addr,
  input logic              test_mode,
  input logic              rd_valid,
  input logic              mem_en,
  input logic              mem_wr,
  input logic [4*IO_W-1:0] mem_wmask
);
  a_r2_entry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && cas_low && we_low && (&row_addr[ENTRY_W-1:0])) |=> test_mode);
  a_r3_bad_row_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && cas_low && we_low && !(&row_addr[ENTRY_W-1:0]) && !test_mode) |=> !test_mode);
  a_r4_cbr_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && cas_low && !we_low) |=> !test_mode);
  a_r6_wcbr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && cas_low && we_low && test_mode) |=> test_mode);
  a_r7_normal_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !test_mode) |-> ($countones(mem_wmask) == IO_W));
  a_r9_test_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && test_mode) |-> (&mem_wmask));
  a_r8_rd_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_wr) |=> rd_valid);
  a_r8_rd_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_en && !mem_wr));
endmodule

bind tmc_datapath tmc_datapath_chk #(.IO_W(IO_W), .ROW_W(ROW_W), .ENTRY_W(ENTRY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_fall(ras_fall), .cas_low(cas_low), .we_low(we_low),
  .row_addr(row_addr), .test_mode(test_mode), .rd_valid(rd_valid), .mem_en(mem_en),
  .mem_wr(mem_wr), .mem_wmask(mem_wmask)
);

// File: tb/tb_tmc_datapath.sv
module tb_tmc_datapath;
  localparam int IO_W = 4, ROW_W = 12, COL_W = 4, WW = 16;

  logic clk = 0, rst_n = 0;
  logic ras_fall = 0, ras_rise = 0, cas_low = 0, we_low = 0;
  logic [ROW_W-1:0] row_addr = '0;
  logic col_valid = 0, col_write = 0;
  logic [COL_W-1:0] col_addr = '0;
  logic [IO_W-1:0] wr_data = '0;
  logic test_mode, rd_valid, mem_en, mem_wr;
  logic [IO_W-1:0] rd_data;
  logic [ROW_W-1:0] mem_row;
  logic [COL_W-3:0] mem_col;
  logic [WW-1:0] mem_wmask, mem_wdata, mem_rdata;

  int tests = 0, fails = 0;
  logic [WW-1:0] store [0:63];
  logic [WW-1:0] model [0:63];
  logic [ROW_W-1:0] cur_row = '0;

  always #2 clk = ~clk;

  tmc_datapath #(.IO_W(IO_W), .ROW_W(ROW_W), .COL_W(COL_W), .ENTRY_W(10)) dut (
    .clk(clk), .rst_n(rst_n), .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_low(cas_low),
    .we_low(we_low), .row_addr(row_addr), .col_valid(col_valid), .col_write(col_write),
    .col_addr(col_addr), .wr_data(wr_data), .test_mode(test_mode), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_en(mem_en), .mem_wr(mem_wr), .mem_row(mem_row), .mem_col(mem_col),
    .mem_wmask(mem_wmask), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_wr)
        store[{mem_row[3:0], mem_col}] <= (store[{mem_row[3:0], mem_col}] & ~mem_wmask) | (mem_wdata & mem_wmask);
      else
        mem_rdata <= store[{mem_row[3:0], mem_col}];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [IO_W-1:0] expect_rd(input logic [WW-1:0] w, input int sel, input logic tm);
    logic [IO_W-1:0] r;
    for (int i = 0; i < IO_W; i++) begin
      logic [3:0] g = w[i*4 +: 4];
      r[i] = tm ? (g == 4'h0 || g == 4'hF) : g[sel];
    end
    return r;
  endfunction

  task automatic ras_down(input logic [ROW_W-1:0] r, input logic cl, input logic wl);
    @(negedge clk);
    ras_fall = 1; cas_low = cl; we_low = wl; row_addr = r;
    if (!cl) cur_row = r;
    @(negedge clk);
    ras_fall = 0; cas_low = 0; we_low = 0;
  endtask

  task automatic ras_up();
    @(negedge clk);
    ras_rise = 1;
    @(negedge clk);
    ras_rise = 0;
  endtask

  task automatic col_wr(input int c, input logic [IO_W-1:0] d, input logic tm);
    int a = {cur_row[3:0], c[3:2]};
    @(negedge clk);
    col_valid = 1; col_write = 1; col_addr = c[COL_W-1:0]; wr_data = d;
    #1;
    chk("R12 row", mem_row, cur_row);
    chk("R12 col", mem_col, c[3:2]);
    for (int i = 0; i < IO_W; i++)
      for (int s = 0; s < 4; s++)
        if (tm || s == c[1:0]) model[a][i*4+s] = d[i];
    if (tm) chk("R9 mask", mem_wmask, 16'hFFFF);
    else    chk("R7 mask", mem_wmask, 16'h1111 << c[1:0]);
    @(negedge clk);
    col_valid = 0; col_write = 0;
  endtask

  task automatic col_rd(input int c, input logic tm, input string req);
    int a = {cur_row[3:0], c[3:2]};
    @(negedge clk);
    col_valid = 1; col_write = 0; col_addr = c[COL_W-1:0];
    @(negedge clk);
    col_valid = 0;
    chk("R8 valid", rd_valid, 1);
    chk(req, rd_data, expect_rd(model[a], c[1:0], tm));
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) begin store[k] = '0; model[k] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 mode", test_mode, 0);
    chk("R1 valid", rd_valid, 0);
    chk("R1 en", mem_en, 0);
    rst_n = 1;

    // R11: access with no open row is dropped
    @(negedge clk); col_valid = 1; col_write = 1; #1;
    chk("R11 closed", mem_en, 0);
    @(negedge clk); col_valid = 0; col_write = 0;

    // Normal mode sweep: R7, R8, R12
    ras_down(12'h005, 0, 0);
    for (int c = 0; c < 16; c++) col_wr(c, 4'((c * 7 + 3) ^ (c >> 2)), 0);
    for (int c = 0; c < 16; c++) col_rd(c, 0, "R8 data");
    ras_up();
    chk("R8 mode", test_mode, 0);

    // R3: each low-bit cleared blocks entry
    for (int b = 0; b < 10; b++) begin
      ras_down(12'h3FF ^ (12'h1 << b), 1, 1);
      chk("R3 no entry", test_mode, 0);
      ras_up();
    end

    // R2 entry with upper bits clear
    ras_down(12'h3FF, 1, 1);
    chk("R2 entry", test_mode, 1);
    ras_up();

    // R9 / R10 compression writes and reads
    ras_down(12'h006, 0, 0);
    for (int w = 0; w < 4; w++) col_wr(w * 4 + w, 4'(w * 5 + 2), 1);
    for (int c = 0; c < 16; c++) col_rd(c, 1, "R10 equal");
    ras_up();
    chk("R6 row kept", test_mode, 1);
    ras_down(12'h005, 0, 0);
    for (int c = 0; c < 16; c += 4) col_rd(c, 1, "R10 mixed");
    ras_up();
    ras_down(12'h000, 1, 1);
    chk("R6 wcbr kept", test_mode, 1);
    ras_up();

    // R4 exit, re-entry with upper bits set, R5 exit
    ras_down(12'h000, 1, 0);
    chk("R4 cbr exit", test_mode, 0);
    ras_up();
    ras_down(12'hFFF, 1, 1);
    chk("R2 upper ignored", test_mode, 1);
    ras_up();
    ras_down(12'h007, 0, 0);
    ras_up();
    chk("R5 ror exit", test_mode, 0);

    // Hidden refresh after a read exits: R4
    ras_down(12'h3FF, 1, 1); ras_up();
    ras_down(12'h006, 0, 0);
    col_rd(0, 1, "R10 before hidden");
    ras_up();
    chk("R6 read row kept", test_mode, 1);
    ras_down(12'h006, 1, 0);
    chk("R4 hidden exit", test_mode, 0);
    ras_up();

    // Break equality bit by bit, then compress-read: R10
    for (int s = 0; s < 4; s++) begin
      ras_down(12'h006, 0, 0);
      col_wr(4 + s, 4'(1 << s), 0);
      ras_up();
      ras_down(12'h3FF, 1, 1); ras_up();
      ras_down(12'h006, 0, 0);
      for (int k = 0; k < 4; k++) col_rd(4 + k, 1, "R10 mismatch");
      ras_up();
      ras_down(12'h000, 1, 0); ras_up();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule